// File: doc/BRIEF.md
# MDIO Management Master

This block is a management-interface master for Ethernet PHYs. Software reaches it through a small register bus. It loads the write data, then writes one command word, and the block shifts a complete clause 22 or clause 45 management frame out on MDC/MDIO. For read frames it releases the data line and captures the PHY's reply. Status flags next to the 16-bit data show whether a frame is still running and whether its result is ready.

One configuration register sets the MDC half-period in core clocks, the preamble and the clause mode. The mode bit changes how the 2-bit opcode in the command word is decoded. Software keeps full control of sequencing. For example, a clause 45 access takes an address frame followed by a data frame, and software issues both.

Top module: `mdio_master`

## Requirements
- R1: After reset, every register reads zero except the configuration register, which reads the RESET_PHASE value in its phase field. The master is disabled. MDC, the MDIO output and its output enable are all low.
- R2: The registers sit at byte offsets 0x00 (command), 0x08 (write data), 0x10 (read data), 0x18 (configuration) and 0x20 (enable). Configuration fields are phase [7:0], sample offset [11:8], preamble [12], idle-clock [13], sample mode [15], high sample offset [20:16] and clause-45 mode [24]. They read back as written, and the unused bits read as zero.
- R3: While the enable bit (offset 0x20, bit 0) is zero, a command write starts no frame and leaves the command register unchanged. MDC stays low.
- R4: A clause 22 write frame is sent MSB first with every bit driven. It carries start 01, opcode 01, a 5-bit PHY address (command bits 12:8), a 5-bit register address (command bits 4:0), turnaround 10 and the 16-bit write data. Each MDC half-period lasts phase core clocks, a phase of 0 counts as 1, and each bit starts with the low half.
- R5: A clause 22 read (command opcode bits 17:16 = 1) sends start 01 and opcode 10. The output enable is released for the two turnaround bits and the 16 data bits, and the MDIO output is low whenever it is not enabled. MDIO input is sampled at each MDC rising edge, and the last 16 samples land in read-data bits 15:0.
- R6: In clause 45 mode the start field is 00 and the command opcode goes on the wire unchanged: 0 is an address frame, 1 a write, 2 a read with increment, 3 a read. Address and write frames carry the write-data register.
- R7: When the preamble bit is set, or clause 45 mode is selected, 32 driven ones precede the frame.
- R8: An accepted command sets the pending flag (bit 17) and clears the valid flag (bit 16). It does this in the read-data register for reads and in the write-data register otherwise. When the frame ends, pending clears and valid sets.
- R9: A command written while a frame is pending is ignored. So is a clause 22 command with opcode 2 or 3. Neither changes the pins, the command register or the flags.
- R10: Writing the enable bit to zero stops a running frame at that clock edge. MDC and the output enable drop, and all pending and valid flags clear while the data fields keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Register byte offset |
| busWrEn | input | 1 | Register write strobe |
| busWrData | input | 32 | Register write data |
| busRdData | output | 32 | Register read data for busAddr (combinational) |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | MDIO drive value |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | MDIO receive value |

## Verification
Some properties are checked on every cycle. The pending flags must track the sequencer's busy state and can never both be set. The released line must stay quiet, MDC must stay low while disabled, a finished frame must always leave a valid flag behind, and a disable write must silence MDC and the output enable on the very next cycle. The exact bit sequences of each frame type, the mode-dependent opcode decoding, the preamble forcing, the half-period timing with phase 0, the captured read words and the rejected commands can only be shown by the bench scenarios. In those scenarios a queue-based model predicts every pin value on every clock.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int REG_W    = 32;
  localparam int DATA_W   = 16;
  localparam int PHASE_W  = 8;
  localparam int CORE_W   = 32;
  localparam int FRAME_W  = 2 * CORE_W;
  localparam int DRIVE_W  = 14;               // start + opcode + phy + register
  localparam int BIT_W    = $clog2(FRAME_W);

  localparam int OFF_CMD  = 'h00;
  localparam int OFF_WDAT = 'h08;
  localparam int OFF_RDAT = 'h10;
  localparam int OFF_CLK  = 'h18;
  localparam int OFF_EN   = 'h20;

  typedef struct packed {
    logic sample;
    logic advance;
    logic done;
  } mdioStrobe_t;

  typedef struct packed {
    logic [FRAME_W-1:0] tx;
    logic [FRAME_W-1:0] oe;
    logic               isRead;
  } mdioFrame_t;

  function automatic logic opAccepted(input logic c45, input logic [1:0] op);
    return c45 || (op[1] == 1'b0);
  endfunction

  function automatic logic opIsRead(input logic c45, input logic [1:0] op);
    return c45 ? op[1] : (op == 2'b01);
  endfunction

  function automatic mdioFrame_t buildFrame(
    input logic c45, input logic pre, input logic [1:0] op,
    input logic [4:0] phy, input logic [4:0] rg, input logic [DATA_W-1:0] wd);
    mdioFrame_t f;
    logic [CORE_W-1:0] core, coreOe;
    logic rd;
    logic [1:0] st, opw, ta;
    rd  = opIsRead(c45, op);
    st  = c45 ? 2'b00 : 2'b01;
    opw = c45 ? op : (op[0] ? 2'b10 : 2'b01);
    ta  = rd ? 2'b00 : 2'b10;
    core   = {st, opw, phy, rg, ta, (rd ? {DATA_W{1'b0}} : wd)};
    coreOe = rd ? {{DRIVE_W{1'b1}}, {(CORE_W-DRIVE_W){1'b0}}} : {CORE_W{1'b1}};
    if (pre) begin
      f.tx = {{CORE_W{1'b1}}, core};
      f.oe = {{CORE_W{1'b1}}, coreOe};
    end else begin
      f.tx = {core, {CORE_W{1'b0}}};
      f.oe = {coreOe, {CORE_W{1'b0}}};
    end
    f.isRead = rd;
    return f;
  endfunction

endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               launch,
  input  logic               kill,
  input  logic [PHASE_W-1:0] halfLen,
  input  logic               longFrame,
  output logic               busy,
  output logic               mdc,
  output mdioStrobe_t        strobe
);

  localparam logic [BIT_W-1:0] LAST_LONG  = BIT_W'(FRAME_W - 1);
  localparam logic [BIT_W-1:0] LAST_SHORT = BIT_W'(CORE_W - 1);

  logic               phaseHigh;
  logic [PHASE_W-1:0] halfCnt;
  logic [PHASE_W-1:0] halfLenQ;
  logic [BIT_W-1:0]   bitCnt;
  logic               longQ;
  logic               halfEnd;
  logic               lastBit;

  assign halfEnd = busy && (halfCnt == halfLenQ - 1'b1);
  assign lastBit = (bitCnt == (longQ ? LAST_LONG : LAST_SHORT));

  always_comb begin
    strobe.sample  = halfEnd && !phaseHigh;
    strobe.advance = halfEnd && phaseHigh && !lastBit;
    strobe.done    = halfEnd && phaseHigh && lastBit;
  end

  assign mdc = busy && phaseHigh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      phaseHigh <= 1'b0;
      halfCnt   <= '0;
      halfLenQ  <= PHASE_W'(1);
      bitCnt    <= '0;
      longQ     <= 1'b0;
    end else if (kill) begin
      busy      <= 1'b0;
      phaseHigh <= 1'b0;
      halfCnt   <= '0;
      bitCnt    <= '0;
    end else if (launch) begin
      busy      <= 1'b1;
      phaseHigh <= 1'b0;
      halfCnt   <= '0;
      bitCnt    <= '0;
      halfLenQ  <= halfLen;
      longQ     <= longFrame;
    end else if (busy) begin
      if (halfEnd) begin
        halfCnt <= '0;
        if (!phaseHigh) begin
          phaseHigh <= 1'b1;
        end else if (lastBit) begin
          busy      <= 1'b0;
          phaseHigh <= 1'b0;
        end else begin
          phaseHigh <= 1'b0;
          bitCnt    <= bitCnt + 1'b1;
        end
      end else begin
        halfCnt <= halfCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
#(
  parameter int                 ADDR_W      = 6,
  parameter logic [PHASE_W-1:0] RESET_PHASE = 8'd4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [REG_W-1:0]   busWrData,
  output logic [REG_W-1:0]   busRdData,
  input  logic               mdioIn,
  input  mdioStrobe_t        strobe,
  input  logic               busy,
  output logic               launch,
  output logic               kill,
  output logic [PHASE_W-1:0] halfLen,
  output logic               longFrame,
  output logic               mdioOut,
  output logic               mdioOe,
  output logic               wrPend,
  output logic               rdPend,
  output logic               wrVal,
  output logic               rdVal,
  output logic               enOn
);

  logic [4:0]         cmdRg, cmdPhy;
  logic [1:0]         cmdOp;
  logic [DATA_W-1:0]  wrData, rdData, rxShift;
  logic [PHASE_W-1:0] cfgPhase;
  logic [3:0]         cfgSamp;
  logic [4:0]         cfgSHi;
  logic               cfgPre, cfgIdle, cfgSMode, cfgMode;
  logic [FRAME_W-1:0] txShift, oeShift;
  logic               hitCmd, hitWdat, hitRdat, hitClk, hitEn;
  mdioFrame_t         frame;

  assign hitCmd  = (busAddr == ADDR_W'(OFF_CMD));
  assign hitWdat = (busAddr == ADDR_W'(OFF_WDAT));
  assign hitRdat = (busAddr == ADDR_W'(OFF_RDAT));
  assign hitClk  = (busAddr == ADDR_W'(OFF_CLK));
  assign hitEn   = (busAddr == ADDR_W'(OFF_EN));

  assign longFrame = cfgPre || cfgMode;
  assign halfLen   = (cfgPhase == '0) ? PHASE_W'(1) : cfgPhase;

  assign frame  = buildFrame(cfgMode, longFrame, busWrData[17:16],
                             busWrData[12:8], busWrData[4:0], wrData);
  assign launch = busWrEn && hitCmd && enOn && !(wrPend || rdPend) &&
                  opAccepted(cfgMode, busWrData[17:16]);
  assign kill   = busWrEn && hitEn && !busWrData[0];

  assign mdioOe  = busy && oeShift[FRAME_W-1];
  assign mdioOut = mdioOe && txShift[FRAME_W-1];

  always_comb begin
    busRdData = '0;
    if (hitCmd)  busRdData = {14'b0, cmdOp, 3'b0, cmdPhy, 3'b0, cmdRg};
    if (hitWdat) busRdData = {14'b0, wrPend, wrVal, wrData};
    if (hitRdat) busRdData = {14'b0, rdPend, rdVal, rdData};
    if (hitClk)  busRdData = {7'b0, cfgMode, 3'b0, cfgSHi, cfgSMode, 1'b0,
                              cfgIdle, cfgPre, cfgSamp, cfgPhase};
    if (hitEn)   busRdData = {31'b0, enOn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdRg    <= '0;
      cmdPhy   <= '0;
      cmdOp    <= '0;
      wrData   <= '0;
      rdData   <= '0;
      rxShift  <= '0;
      wrPend   <= 1'b0;
      rdPend   <= 1'b0;
      wrVal    <= 1'b0;
      rdVal    <= 1'b0;
      cfgPhase <= RESET_PHASE;
      cfgSamp  <= '0;
      cfgSHi   <= '0;
      cfgPre   <= 1'b0;
      cfgIdle  <= 1'b0;
      cfgSMode <= 1'b0;
      cfgMode  <= 1'b0;
      enOn     <= 1'b0;
      txShift  <= '0;
      oeShift  <= '0;
    end else begin
      if (busWrEn && hitWdat) wrData <= busWrData[DATA_W-1:0];
      if (busWrEn && hitClk) begin
        cfgPhase <= busWrData[7:0];
        cfgSamp  <= busWrData[11:8];
        cfgPre   <= busWrData[12];
        cfgIdle  <= busWrData[13];
        cfgSMode <= busWrData[15];
        cfgSHi   <= busWrData[20:16];
        cfgMode  <= busWrData[24];
      end
      if (busWrEn && hitEn) enOn <= busWrData[0];
      if (launch) begin
        cmdRg   <= busWrData[4:0];
        cmdPhy  <= busWrData[12:8];
        cmdOp   <= busWrData[17:16];
        txShift <= frame.tx;
        oeShift <= frame.oe;
        if (frame.isRead) begin
          rdPend <= 1'b1;
          rdVal  <= 1'b0;
        end else begin
          wrPend <= 1'b1;
          wrVal  <= 1'b0;
        end
      end
      if (strobe.advance) begin
        txShift <= {txShift[FRAME_W-2:0], 1'b0};
        oeShift <= {oeShift[FRAME_W-2:0], 1'b0};
      end
      if (strobe.sample) rxShift <= {rxShift[DATA_W-2:0], mdioIn};
      if (strobe.done) begin
        if (rdPend) begin
          rdData <= rxShift;
          rdVal  <= 1'b1;
        end else begin
          wrVal <= 1'b1;
        end
        rdPend <= 1'b0;
        wrPend <= 1'b0;
      end
      if (kill) begin
        wrPend <= 1'b0;
        rdPend <= 1'b0;
        wrVal  <= 1'b0;
        rdVal  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int                 ADDR_W      = 6,
  parameter logic [PHASE_W-1:0] RESET_PHASE = 8'd4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [REG_W-1:0]  busWrData,
  output logic [REG_W-1:0]  busRdData,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);

  mdioStrobe_t        strobe;
  logic               ctrlBusy, launch, killReq, longFrame;
  logic [PHASE_W-1:0] halfLen;
  logic               wrPend, rdPend, wrVal, rdVal, enOn;

  mdio_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .launch    (launch),
    .kill      (killReq),
    .halfLen   (halfLen),
    .longFrame (longFrame),
    .busy      (ctrlBusy),
    .mdc       (mdc),
    .strobe    (strobe)
  );

  mdio_datapath #(.ADDR_W(ADDR_W), .RESET_PHASE(RESET_PHASE)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .mdioIn    (mdioIn),
    .strobe    (strobe),
    .busy      (ctrlBusy),
    .launch    (launch),
    .kill      (killReq),
    .halfLen   (halfLen),
    .longFrame (longFrame),
    .mdioOut   (mdioOut),
    .mdioOe    (mdioOe),
    .wrPend    (wrPend),
    .rdPend    (rdPend),
    .wrVal     (wrVal),
    .rdVal     (rdVal),
    .enOn      (enOn)
  );

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic clk,
  input logic rstN,
  input logic mdc,
  input logic mdioOut,
  input logic mdioOe,
  input logic busy,
  input logic wrPend,
  input logic rdPend,
  input logic wrVal,
  input logic rdVal,
  input logic enOn,
  input logic killReq
);

  // R5: a released line is never driven high
  a_r5_released_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !mdioOe |-> !mdioOut);

  // R8: register flags follow the sequencer
  a_r8_pend_tracks_busy: assert property (@(posedge clk) disable iff (!rstN)
    (wrPend || rdPend) == busy);

  a_r8_pend_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wrPend, rdPend}));

  a_r8_done_sets_valid: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(wrPend || rdPend) && enOn) |-> (wrVal || rdVal));

  // R3: no clock while disabled
  a_r3_gate_mdc: assert property (@(posedge clk) disable iff (!rstN)
    !enOn |-> !mdc);

  // R10: disable write silences the pins next cycle
  a_r10_abort: assert property (@(posedge clk) disable iff (!rstN)
    killReq |=> (!mdc && !mdioOe && !wrPend && !rdPend));

endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .mdc     (mdc),
  .mdioOut (mdioOut),
  .mdioOe  (mdioOe),
  .busy    (ctrlBusy),
  .wrPend  (wrPend),
  .rdPend  (rdPend),
  .wrVal   (wrVal),
  .rdVal   (rdVal),
  .enOn    (enOn),
  .killReq (killReq)
);

// File: tb/tb_mdio_master.sv
`timescale 1ns/1ps
module tb_mdio_master;

  localparam int A_CMD = 'h00, A_WDAT = 'h08, A_RDAT = 'h10, A_CLK = 'h18, A_EN = 'h20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;

  int nCmp = 0, nBad = 0;
  bit running = 1'b0;
  string curReq = "R1";

  // model state
  logic [3:0] q[$];            // {mdc, out, oe, in} per core clock
  bit         mEn = 0, mPre = 0, mMode = 0;
  int         mPhase = 4;
  int         mWd = 0;
  int         resp = 0;

  always #2.5 clk = ~clk;

  mdio_master dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
  endtask

  // per-cycle pin comparison
  always @(negedge clk) begin
    if (running) begin
      logic [3:0] e;
      if (q.size() > 0) e = q.pop_front();
      else e = 4'b0001;
      mdioIn <= e[0];
      nCmp++;
      if ({mdc, mdioOut, mdioOe} !== e[3:1]) begin
        nBad++;
        $display("FAIL %s pins mdc/out/oe actual %b expected %b at %0t",
                 curReq, {mdc, mdioOut, mdioOe}, e[3:1], $time);
      end
    end
  end

  task automatic pushBit(input bit o, input bit oe, input bit inb);
    int p;
    p = (mPhase == 0) ? 1 : mPhase;
    for (int k = 0; k < p; k++) q.push_back({1'b0, o, oe, inb});
    for (int k = 0; k < p; k++) q.push_back({1'b1, o, oe, inb});
  endtask

  task automatic buildQueue(input int op, input int phy, input int rg);
    bit rd;
    int st, opw, word;
    rd  = mMode ? (op >= 2) : (op == 1);
    st  = mMode ? 0 : 1;
    opw = mMode ? op : ((op == 0) ? 1 : 2);
    word = (st << 30) | (opw << 28) | (phy << 23) | (rg << 18) |
           ((rd ? 0 : 2) << 16) | (rd ? 0 : (mWd & 'hFFFF));
    if (mPre || mMode)
      for (int i = 0; i < 32; i++) pushBit(1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 32; i++) begin
      bit oe, o, inb;
      oe  = rd ? (i < 14) : 1'b1;
      o   = oe ? word[31-i] : 1'b0;
      inb = (rd && i >= 16) ? resp[31-i] : 1'b1;
      pushBit(o, oe, inb);
    end
  endtask

  task automatic busWrite(input int a, input int d);
    @(negedge clk);
    busAddr   = 6'(a);
    busWrData = d;
    busWrEn   = 1'b1;
    @(posedge clk);
    #1;
    busWrEn = 1'b0;
    case (a)
      A_CLK:  begin mPhase = d & 'hFF; mPre = d[12]; mMode = d[24]; end
      A_WDAT: mWd = d & 'hFFFF;
      A_EN:   begin mEn = d[0]; if (!d[0]) q.delete(); end
      A_CMD: begin
        int op;
        op = (d >> 16) & 3;
        if (mEn && q.size() == 0 && (mMode || op < 2))
          buildQueue(op, (d >> 8) & 'h1F, d & 'h1F);
      end
      default: ;
    endcase
  endtask

  task automatic checkReg(input int a, input int exp, input string req);
    @(negedge clk);
    busAddr = 6'(a);
    #1;
    nCmp++;
    if (busRdData !== 32'(exp)) begin
      nBad++;
      $display("FAIL %s reg 0x%02h actual 0x%08h expected 0x%08h", req, a, busRdData, exp);
    end
  endtask

  task automatic waitIdle();
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    running = 1'b1;

    // R1 reset state
    curReq = "R1";
    checkReg(A_CMD, 0, "R1");
    checkReg(A_WDAT, 0, "R1");
    checkReg(A_RDAT, 0, "R1");
    checkReg(A_CLK, 4, "R1");
    checkReg(A_EN, 0, "R1");

    // R2 configuration fields, reserved bits dropped
    curReq = "R2";
    busWrite(A_CLK, 32'hFE05A302);
    checkReg(A_CLK, 32'h0005A302, "R2");

    // R3 commands ignored while disabled
    curReq = "R3";
    busWrite(A_WDAT, 'h1234);
    busWrite(A_CMD, 'h00000511);
    repeat (10) @(posedge clk);
    checkReg(A_CMD, 0, "R3");
    checkReg(A_WDAT, 'h1234, "R3");

    // R4 clause 22 write, phase 2; R8 pending; R9 ignored while busy
    curReq = "R4";
    busWrite(A_EN, 1);
    busWrite(A_CMD, 'h00000511);
    checkReg(A_WDAT, 'h21234, "R8");
    busWrite(A_CMD, 'h00010203);
    checkReg(A_CMD, 'h00000511, "R9");
    checkReg(A_RDAT, 0, "R9");
    waitIdle();
    checkReg(A_WDAT, 'h11234, "R8");

    // R5 clause 22 read
    curReq = "R5";
    resp = 'hBEEF;
    busWrite(A_CMD, 'h00010302);
    checkReg(A_RDAT, 'h20000, "R8");
    waitIdle();
    checkReg(A_RDAT, 'h1BEEF, "R5");
    checkReg(A_WDAT, 'h11234, "R8");

    // R9 invalid clause 22 opcode
    curReq = "R9";
    busWrite(A_CMD, 'h00020302);
    repeat (10) @(posedge clk);
    checkReg(A_CMD, 'h00010302, "R9");
    checkReg(A_RDAT, 'h1BEEF, "R9");

    // R7 preamble by bit, phase 1
    curReq = "R7";
    busWrite(A_CLK, 'h1101);
    busWrite(A_WDAT, 'hA5A5);
    busWrite(A_CMD, 'h00001F1F);
    waitIdle();
    checkReg(A_WDAT, 'h1A5A5, "R7");

    // R6 clause 45 with forced preamble (R7), phase 0 counts as 1 (R4)
    curReq = "R6";
    busWrite(A_CLK, 'h01000000);
    checkReg(A_CLK, 'h01000000, "R2");
    busWrite(A_WDAT, 'hC003);
    busWrite(A_CMD, 'h00000104);
    waitIdle();
    checkReg(A_WDAT, 'h1C003, "R6");
    busWrite(A_WDAT, 'h0005);
    busWrite(A_CMD, 'h00010104);
    waitIdle();
    checkReg(A_WDAT, 'h10005, "R6");
    resp = 'h8001;
    busWrite(A_CMD, 'h00030104);
    waitIdle();
    checkReg(A_RDAT, 'h18001, "R6");
    resp = 'h00A5;
    busWrite(A_CMD, 'h00020104);
    waitIdle();
    checkReg(A_RDAT, 'h100A5, "R6");
    checkReg(A_CMD, 'h00020104, "R6");

    // R10 abort mid-frame
    curReq = "R10";
    busWrite(A_CLK, 'h3);
    resp = 'h7777;
    busWrite(A_CMD, 'h00010700);
    repeat (20) @(posedge clk);
    busWrite(A_EN, 0);
    repeat (5) @(posedge clk);
    checkReg(A_RDAT, 'h000A5, "R10");
    checkReg(A_WDAT, 'h00005, "R10");
    checkReg(A_EN, 0, "R10");
    busWrite(A_EN, 1);
    busWrite(A_WDAT, 'h0F0F);
    busWrite(A_CMD, 'h00000700);
    waitIdle();
    checkReg(A_WDAT, 'h10F0F, "R10");

    repeat (4) @(posedge clk);
    summary();
    $finish;
  end

endmodule